// File: doc/BRIEF.md
# Real-Time Clock Alarm Repeat Match Unit

This block keeps the four alarm fields of a battery-backed real-time clock (second, minute, hour, day of month) and compares them against the running BCD time once per second. When the enabled fields agree, it raises a single-cycle interrupt pulse. The timekeeping counters live outside the block. They present the current time as four BCD bytes, together with a one-cycle `tick_1s` strobe in the cycle where that time becomes current.

Each alarm byte holds a "don't care" flag in bit 7 and a BCD value in the low bits. The pattern of the four flags sets the repeat rate: monthly, daily, hourly, once a minute or once a second. A host loads the fields one byte at a time over a valid/ready write stream. `wr_ready` stays high at all times, so the block never applies back-pressure, and a beat is taken in every cycle where `wr_valid` is high. A beat whose BCD value is out of range for its field is consumed but leaves the field unchanged.

Top module: `rtc_alarm_match`

## Requirements
- R1: `wr_ready` is always 1. Every cycle with `wr_valid` high is one write beat. `wr_sel` picks the field: 0 = second, 1 = minute, 2 = hour, 3 = day of month.
- R2: A second or minute write is stored, all 8 bits, only when `wr_data[6:0]` is valid BCD (each nibble at most 9) with a value from 0 to 59. Otherwise the field keeps its old value.
- R3: An hour write is stored only when `wr_data[5:0]` is valid BCD from 0 to 23. Otherwise the field keeps its old value.
- R4: A day write is stored only when `wr_data[5:0]` is valid BCD from 1 to 31. Otherwise the field keeps its old value.
- R5: Bit 7 of each field is its mask. With all four masks clear, a tick raises the alarm only when day, second, minute and hour all equal the current time. Bits [6:0] are compared for second and minute, and bits [5:0] for hour and day.
- R6: With only the day mask set, a tick raises the alarm when hour, minute and second match. The day is ignored.
- R7: With the day and hour masks set, and minute and second unmasked, a tick raises the alarm when minute and second match.
- R8: With day, hour and minute masked and second unmasked, the alarm fires when the second matches. With all four masked, every tick fires.
- R9: Any other mask pattern, for example only the minute mask set, fires on every tick.
- R10: `alarm_irq` is high for exactly the one cycle after a tick whose time matches. It never rises without a tick in the previous cycle.
- R11: Reset clears all four fields to 0x00 and holds `alarm_irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always 1, no back-pressure |
| wr_sel | input | 2 | Field select: 0 sec, 1 min, 2 hour, 3 day |
| wr_data | input | 8 | Mask bit 7 plus BCD value |
| tick_1s | input | 1 | One-cycle strobe per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
A write beat presented in cycle N is stored at the edge that ends cycle N, so a tick issued in cycle N+1 already compares against the new field. A tick in cycle T produces `alarm_irq` during cycle T+1 only. The bench drives inputs on the falling edge. It reads `alarm_irq` on the next falling edge, where the pulse must be high, and again one falling edge later, where it must be low again. Write rejection is observed only through this pulse: the bench ticks with the old value, which must still fire, and then with the rejected value, which must not.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int DATA_W  = 8;
  localparam int FIELDS  = 4;
  localparam int SEL_W   = $clog2(FIELDS);
  localparam int MASK_B  = DATA_W - 1;

  // field indices; order used by wr_sel
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } rpt_e;

  function automatic int fld_bits(input int f);
    return (f == F_SEC || f == F_MIN) ? 7 : 6;
  endfunction

  function automatic int fld_lo(input int f);
    return (f == F_DAY) ? 1 : 0;
  endfunction

  function automatic int fld_hi(input int f);
    case (f)
      F_HOUR:  return 23;
      F_DAY:   return 31;
      default: return 59;
    endcase
  endfunction

  function automatic logic bcd_ok(input logic [6:0] v, input int lo, input int hi);
    int n;
    if (v[3:0] > 4'd9) return 1'b0;
    n = 32'(v[6:4]) * 10 + 32'(v[3:0]);
    return (n >= lo) && (n <= hi);
  endfunction

endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg
  import rtc_alarm_pkg::*;
#(
  parameter int VAL_BITS = 7,
  parameter int MIN_VAL  = 0,
  parameter int MAX_VAL  = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);

  logic [6:0] val7;
  logic       in_range;

  always_comb begin
    val7     = 7'(wr_data[VAL_BITS-1:0]);
    in_range = bcd_ok(val7, MIN_VAL, MAX_VAL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                q <= '0;
    else if (wr_en && in_range) q <= wr_data;
  end

  // R2 R3 R4: bad BCD leaves the field alone
  p_reject_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> $stable(q));

  // R2 R3 R4: good BCD lands whole byte
  p_accept_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_range) |=> (q == $past(wr_data)));

endmodule

// File: rtl/alarm_repeat_decode.sv
module alarm_repeat_decode
  import rtc_alarm_pkg::*;
(
  input  logic [FIELDS-1:0] mask,
  output rpt_e              rate,
  output logic [FIELDS-1:0] cmp_en
);

  // mask index order: [3]=day [2]=hour [1]=min [0]=sec
  always_comb begin
    case (mask)
      4'b0000: begin rate = RPT_MONTH; cmp_en = 4'b1111; end
      4'b1000: begin rate = RPT_DAY;   cmp_en = 4'b0111; end
      4'b1100: begin rate = RPT_HOUR;  cmp_en = 4'b0011; end
      4'b1110: begin rate = RPT_MIN;   cmp_en = 4'b0001; end
      default: begin rate = RPT_SEC;   cmp_en = 4'b0000; end
    endcase
  end

endmodule

// File: rtl/alarm_match_core.sv
module alarm_match_core
  import rtc_alarm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [FIELDS-1:0][DATA_W-1:0] alarm_q,
  input  logic [FIELDS-1:0][DATA_W-1:0] now_t,
  input  logic [FIELDS-1:0]             cmp_en,
  output logic                          irq
);

  logic [FIELDS-1:0] field_eq;
  logic              hit;

  for (genvar g = 0; g < FIELDS; g++) begin : g_cmp
    localparam logic [DATA_W-1:0] VMASK = DATA_W'((1 << fld_bits(g)) - 1);
    assign field_eq[g] = ((alarm_q[g] & VMASK) == (now_t[g] & VMASK));
  end

  assign hit = &(field_eq | ~cmp_en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick && hit;
  end

  // R10: pulse only follows a tick
  p_irq_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));

  // R8 R9: nothing to compare means every tick fires
  p_free_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmp_en == '0) |=> irq);

  // R11: reset holds the output low
  p_reset_low_r11: assert property (@(posedge clk)
    !rst_n |=> !irq);

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [1:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic        tick_1s,
  input  logic [7:0]  now_sec,
  input  logic [7:0]  now_min,
  input  logic [7:0]  now_hour,
  input  logic [7:0]  now_date,
  output logic        alarm_irq
);

  logic [FIELDS-1:0][DATA_W-1:0] alarm_q;
  logic [FIELDS-1:0][DATA_W-1:0] now_t;
  logic [FIELDS-1:0]             mask;
  logic [FIELDS-1:0]             cmp_en;
  rpt_e                          rate;

  assign wr_ready = 1'b1;

  assign now_t[F_SEC]  = now_sec;
  assign now_t[F_MIN]  = now_min;
  assign now_t[F_HOUR] = now_hour;
  assign now_t[F_DAY]  = now_date;

  for (genvar g = 0; g < FIELDS; g++) begin : g_fld
    alarm_field_reg #(
      .VAL_BITS (fld_bits(g)),
      .MIN_VAL  (fld_lo(g)),
      .MAX_VAL  (fld_hi(g))
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_valid && (wr_sel == SEL_W'(g))),
      .wr_data (wr_data),
      .q       (alarm_q[g])
    );
    assign mask[g] = alarm_q[g][MASK_B];
  end

  alarm_repeat_decode u_dec (
    .mask   (mask),
    .rate   (rate),
    .cmp_en (cmp_en)
  );

  alarm_match_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1s),
    .alarm_q (alarm_q),
    .now_t   (now_t),
    .cmp_en  (cmp_en),
    .irq     (alarm_irq)
  );

  // R1: never back-pressures
  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);

  // R5: a monthly setting compares every field
  p_month_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == RPT_MONTH) |-> (cmp_en == '1));

endmodule

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       tick_1s = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
  logic       alarm_irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rtc_alarm_match u_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .tick_1s(tick_1s),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .alarm_irq(alarm_irq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, m, h, d);
    wr(2'd0, s); wr(2'd1, m); wr(2'd2, h); wr(2'd3, d);
  endtask

  // tick with a time; expect pulse next cycle (or none), then low again
  task automatic tick_at(input logic [7:0] d, h, m, s, input logic exp, input string req);
    @(negedge clk);
    now_date = d; now_hour = h; now_min = m; now_sec = s; tick_1s = 1'b1;
    @(negedge clk);
    tick_1s = 1'b0;
    check(alarm_irq == exp, req, alarm_irq, exp);
    @(negedge clk);
    check(alarm_irq == 1'b0, {req, " pulse end R10"}, alarm_irq, 0);
  endtask

  task automatic t_reset;
    check(alarm_irq == 1'b0, "R11 irq low", alarm_irq, 0);
    tick_at(8'h01, 8'h00, 8'h00, 8'h00, 1'b0, "R11 cleared day");
    tick_at(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, "R11 cleared all");
  endtask

  task automatic t_month;
    set_all(8'h30, 8'h15, 8'h12, 8'h20);
    tick_at(8'h20, 8'h12, 8'h15, 8'h30, 1'b1, "R5 full match");
    tick_at(8'h20, 8'h12, 8'h15, 8'h31, 1'b0, "R5 sec off");
    tick_at(8'h21, 8'h12, 8'h15, 8'h30, 1'b0, "R5 day off");
    @(negedge clk);
    now_date = 8'h20; now_hour = 8'h12; now_min = 8'h15; now_sec = 8'h30;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(alarm_irq == 1'b0, "R10 no tick", alarm_irq, 0);
    end
  endtask

  task automatic t_day;
    wr(2'd3, 8'hA0);
    tick_at(8'h05, 8'h12, 8'h15, 8'h30, 1'b1, "R6 daily");
    tick_at(8'h05, 8'h13, 8'h15, 8'h30, 1'b0, "R6 hour off");
  endtask

  task automatic t_hour;
    wr(2'd2, 8'h92);
    tick_at(8'h05, 8'h07, 8'h15, 8'h30, 1'b1, "R7 hourly");
    tick_at(8'h05, 8'h07, 8'h16, 8'h30, 1'b0, "R7 min off");
  endtask

  task automatic t_minute;
    wr(2'd1, 8'h95);
    tick_at(8'h09, 8'h01, 8'h44, 8'h30, 1'b1, "R8 per minute");
    tick_at(8'h09, 8'h01, 8'h44, 8'h31, 1'b0, "R8 sec off");
    wr(2'd0, 8'hB0);
    tick_at(8'h02, 8'h03, 8'h04, 8'h05, 1'b1, "R8 every second");
  endtask

  task automatic t_other;
    set_all(8'h30, 8'h95, 8'h12, 8'h20);
    tick_at(8'h11, 8'h02, 8'h00, 8'h05, 1'b1, "R9 min mask only");
    set_all(8'h30, 8'h15, 8'h92, 8'h20);
    tick_at(8'h11, 8'h02, 8'h00, 8'h05, 1'b1, "R9 hour mask only");
  endtask

  task automatic t_ranges;
    set_all(8'h30, 8'h15, 8'h12, 8'h20);
    wr(2'd0, 8'h60);
    wr(2'd0, 8'h5A);
    tick_at(8'h20, 8'h12, 8'h15, 8'h30, 1'b1, "R2 sec kept");
    tick_at(8'h20, 8'h12, 8'h15, 8'h60, 1'b0, "R2 sec 60 rejected");
    wr(2'd0, 8'h59);
    tick_at(8'h20, 8'h12, 8'h15, 8'h59, 1'b1, "R2 sec 59 taken");
    wr(2'd1, 8'h7F);
    tick_at(8'h20, 8'h12, 8'h15, 8'h59, 1'b1, "R2 min kept");
    wr(2'd2, 8'h24);
    tick_at(8'h20, 8'h12, 8'h15, 8'h59, 1'b1, "R3 hour kept");
    wr(2'd2, 8'h23);
    tick_at(8'h20, 8'h23, 8'h15, 8'h59, 1'b1, "R3 hour 23 taken");
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h32);
    tick_at(8'h20, 8'h23, 8'h15, 8'h59, 1'b1, "R4 day kept");
    wr(2'd3, 8'h31);
    tick_at(8'h31, 8'h23, 8'h15, 8'h59, 1'b1, "R4 day 31 taken");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_month;
    t_day;
    t_hour;
    t_minute;
    t_other;
    t_ranges;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule